// File: doc/BRIEF.md
# Sigma-Delta Calibration Sequencer

This block runs the offset and gain calibration of a dual-channel one-bit sigma-delta modulator from the digital side. On a start request it pulses the modulator reset. It then waits out the data-valid blanking and settling time and applies the zero-input control. After a settle interval it counts the ones on both bitstreams over a programmable window. It then drops the zero-input control, waits, and repeats the settle and count with the gain control raised.

Each window's ones count is compared with the ideal count for its phase. In the zero-input phase the ideal density is one half in bipolar mode and three eighths in unipolar mode. In the gain phase it is five eighths in both modes. The difference is reported as a signed fixed-point error with eight fractional bits per channel. A drop of the data-valid flag inside a window aborts that window and repeats the phase, up to a limit. The results hold only for the input mode that was selected at start. Any later change of the mode input withdraws the done flag.

Top module: `cal_seq_top`

## Requirements
- R1: In reset all outputs are low or zero. A start pulse is accepted only while `busy_o` is low and `win_len_i` is nonzero. It raises `busy_o` on the next cycle. A start pulse while busy, or with a zero window, has no effect. With no run active, no control line is driven.
- R2: An accepted start raises `mod_rst_o` on the next cycle and holds it for exactly RST_CYC cycles.
- R3: `zero_in_o` rises exactly DVAL_LOW_CYC+SETTLE_CYC cycles after `mod_rst_o` falls.
- R4: Without aborts, `zero_in_o` and `gain_in_o` each stay high for SETTLE_CYC+W cycles, where W is the window latched at start. Only the last W of those cycles are counted.
- R5: `zero_in_o` and `gain_in_o` are never high together. `gain_in_o` rises exactly SETTLE_CYC cycles after `zero_in_o` falls.
- R6: The offset error per channel is ones*256 − W*D as a signed RES_W value with 8 fractional bits. D is 128 when `mode_bip_i`=1 (bipolar) and 96 when `mode_bip_i`=0 (unipolar), using the mode sampled at start.
- R7: The gain error per channel is ones*256 − W*160 in either mode.
- R8: `done_o` rises, and `busy_o` falls, on the same cycle that `gain_in_o` falls. `done_o` then holds until the next accepted start or a mode change.
- R9: `dval_i` low during a counting cycle aborts the window and raises `err_o`. The phase then restarts from its settle interval with its control still high. The reported error comes from a later full clean window.
- R10: After MAX_RETRY restarts of one phase, a further abort ends the run with `busy_o`, `done_o` and all control lines low and `err_o` high.
- R11: Any change of `mode_bip_i` clears `done_o` on the next cycle. A run during which the mode changed ends with `done_o` low.
- R12: `err_o` is cleared by an accepted start and otherwise holds.

Ports (widths use the defaults WIN_W=15, RES_W=24):

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, one bitstream bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration start request |
| mode_bip_i | input | 1 | 1 selects bipolar, 0 unipolar input mode |
| win_len_i | input | WIN_W | Counting window length in cycles |
| dval_i | input | 1 | Modulator data-valid flag |
| bit_a_i | input | 1 | Channel A bitstream |
| bit_b_i | input | 1 | Channel B bitstream |
| mod_rst_o | output | 1 | Modulator reset control |
| zero_in_o | output | 1 | Zero-input (offset) control |
| gain_in_o | output | 1 | Gain-calibration control |
| off_err_a_o | output | RES_W | Channel A offset error, signed, 8 fractional bits |
| off_err_b_o | output | RES_W | Channel B offset error, signed, 8 fractional bits |
| gain_err_a_o | output | RES_W | Channel A gain error, signed, 8 fractional bits |
| gain_err_b_o | output | RES_W | Channel B gain error, signed, 8 fractional bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Results valid for the current mode |
| err_o | output | 1 | A counting window was aborted in this run |

## Verification
The hardest states to reach are the abort paths. The counting window is never visible at the ports, so a data-valid drop has to land inside it. The stimulus times each drop from the observed rise of the zero-input control, counting a fixed offset past the settle interval. It also holds data-valid low through every restart to exhaust the retry budget. The bitstreams use rotating 8-bit patterns with window lengths that are multiples of eight. This makes the ones count in any window exact regardless of where the window starts, so the expected errors hold even after restarts shift the timing.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_RWAIT,
      ST_ZSET,
      ST_ZCNT,
      ST_ZOFF,
      ST_GSET,
      ST_GCNT
   } cal_state_e;

   // ideal ones densities, Q0.8
   localparam logic [7:0] DENS_ZERO_BIP = 8'd128;
   localparam logic [7:0] DENS_ZERO_UNI = 8'd96;
   localparam logic [7:0] DENS_GAIN     = 8'd160;

   function automatic logic [7:0] zero_density(input logic bip);
      return bip ? DENS_ZERO_BIP : DENS_ZERO_UNI;
   endfunction

endpackage

// File: rtl/cal_interval_timer.sv
module cal_interval_timer #(
   parameter int TW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          expired_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (load_i)          cnt_q <= val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cal_ones_tally.sv
module cal_ones_tally #(
   parameter int CW = 15
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          en_i,
   input  logic          bit_i,
   output logic [CW-1:0] sum_o
);
   logic [CW-1:0] acc_q;

   // running total including the current bit
   assign sum_o = acc_q + CW'(en_i & bit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (clr_i)  acc_q <= '0;
      else if (en_i)   acc_q <= sum_o;
   end
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
   import cal_seq_pkg::*;
#(
   parameter int WIN_W        = 15,
   parameter int RES_W        = 24,
   parameter int RST_CYC      = 4,
   parameter int DVAL_LOW_CYC = 20,
   parameter int SETTLE_CYC   = 1000,
   parameter int MAX_RETRY    = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic                    mode_bip_i,
   input  logic [WIN_W-1:0]        win_len_i,
   input  logic                    dval_i,
   input  logic                    bit_a_i,
   input  logic                    bit_b_i,
   output logic                    mod_rst_o,
   output logic                    zero_in_o,
   output logic                    gain_in_o,
   output logic signed [RES_W-1:0] off_err_a_o,
   output logic signed [RES_W-1:0] off_err_b_o,
   output logic signed [RES_W-1:0] gain_err_a_o,
   output logic signed [RES_W-1:0] gain_err_b_o,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    err_o
);
   localparam int NCH       = 2;
   localparam int LONG_WAIT = DVAL_LOW_CYC + SETTLE_CYC;
   localparam int WIN_MAX   = (1 << WIN_W);
   localparam int MAXV      = (LONG_WAIT > WIN_MAX) ? LONG_WAIT : WIN_MAX;
   localparam int TW        = $clog2(MAXV + 1);
   localparam int RW        = $clog2(MAX_RETRY + 2);

   if (RES_W < WIN_W + 9) begin : g_bad_res
      $error("RES_W too narrow for WIN_W plus 8 fraction bits and sign");
   end
   if (RST_CYC < 1 || SETTLE_CYC < 1 || DVAL_LOW_CYC < 0) begin : g_bad_time
      $error("interval parameters out of range");
   end
   if (MAX_RETRY < 0) begin : g_bad_retry
      $error("MAX_RETRY must not be negative");
   end

   cal_state_e        st_q, st_d;
   logic              tmr_load, tmr_exp;
   logic [TW-1:0]     tmr_val;
   logic [WIN_W-1:0]  win_q;
   logic              mode_q, mode_d_q, stale_q;
   logic [RW-1:0]     retry_q;
   logic              begin_run, abort, fail, fin_zero, fin_gain;
   logic              done_q, err_q;
   logic              counting, tally_clr;
   logic [7:0]        dens;
   logic [NCH-1:0]    bits;
   logic              mode_chg;

   assign bits      = {bit_b_i, bit_a_i};
   assign counting  = (st_q == ST_ZCNT) || (st_q == ST_GCNT);
   assign tally_clr = (st_q == ST_ZSET) || (st_q == ST_GSET);
   assign dens      = (st_q == ST_ZCNT) ? zero_density(mode_q) : DENS_GAIN;
   assign mode_chg  = (mode_bip_i != mode_d_q);

   cal_interval_timer #(.TW(TW)) tmr_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load),
      .val_i     (tmr_val),
      .expired_o (tmr_exp)
   );

   always_comb begin
      st_d      = st_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      begin_run = 1'b0;
      abort     = 1'b0;
      fail      = 1'b0;
      fin_zero  = 1'b0;
      fin_gain  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start_i && win_len_i != '0) begin
            st_d = ST_RST; tmr_load = 1'b1; tmr_val = TW'(RST_CYC - 1); begin_run = 1'b1;
         end
         ST_RST: if (tmr_exp) begin
            st_d = ST_RWAIT; tmr_load = 1'b1; tmr_val = TW'(LONG_WAIT - 1);
         end
         ST_RWAIT, ST_ZOFF: if (tmr_exp) begin
            st_d = (st_q == ST_RWAIT) ? ST_ZSET : ST_GSET;
            tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC - 1);
         end
         ST_ZSET, ST_GSET: if (tmr_exp) begin
            st_d = (st_q == ST_ZSET) ? ST_ZCNT : ST_GCNT;
            tmr_load = 1'b1; tmr_val = TW'(win_q) - TW'(1);
         end
         ST_ZCNT, ST_GCNT: begin
            if (!dval_i) begin
               abort = 1'b1;
               if (retry_q < RW'(MAX_RETRY)) begin
                  st_d = (st_q == ST_ZCNT) ? ST_ZSET : ST_GSET;
                  tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC - 1);
               end else begin
                  st_d = ST_IDLE; fail = 1'b1;
               end
            end else if (tmr_exp) begin
               if (st_q == ST_ZCNT) begin
                  st_d = ST_ZOFF; tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC - 1);
                  fin_zero = 1'b1;
               end else begin
                  st_d = ST_IDLE; fin_gain = 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         win_q    <= '0;
         mode_q   <= 1'b0;
         mode_d_q <= 1'b0;
         stale_q  <= 1'b0;
         retry_q  <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         st_q     <= st_d;
         mode_d_q <= mode_bip_i;
         if (begin_run) begin
            win_q  <= win_len_i;
            mode_q <= mode_bip_i;
         end
         if (begin_run || fin_zero) retry_q <= '0;
         else if (abort && !fail)   retry_q <= retry_q + RW'(1);
         if (begin_run)      stale_q <= 1'b0;
         else if (mode_chg)  stale_q <= 1'b1;
         if (begin_run || mode_chg)    done_q <= 1'b0;
         else if (fin_gain && !stale_q) done_q <= 1'b1;
         if (begin_run)  err_q <= 1'b0;
         else if (abort) err_q <= 1'b1;
      end
   end

   logic [RES_W-1:0] off_q  [NCH];
   logic [RES_W-1:0] gain_q [NCH];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic [WIN_W-1:0] sum;
      logic [RES_W-1:0] diff;

      cal_ones_tally #(.CW(WIN_W)) tally_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (tally_clr),
         .en_i   (counting && dval_i),
         .bit_i  (bits[ch]),
         .sum_o  (sum)
      );

      assign diff = (RES_W'(sum) << 8) - (RES_W'(win_q) * RES_W'(dens));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            off_q[ch]  <= '0;
            gain_q[ch] <= '0;
         end else begin
            if (fin_zero) off_q[ch]  <= diff;
            if (fin_gain) gain_q[ch] <= diff;
         end
      end
   end

   assign mod_rst_o    = (st_q == ST_RST);
   assign zero_in_o    = (st_q == ST_ZSET) || (st_q == ST_ZCNT);
   assign gain_in_o    = (st_q == ST_GSET) || (st_q == ST_GCNT);
   assign busy_o       = (st_q != ST_IDLE);
   assign done_o       = done_q;
   assign err_o        = err_q;
   assign off_err_a_o  = $signed(off_q[0]);
   assign off_err_b_o  = $signed(off_q[1]);
   assign gain_err_a_o = $signed(gain_q[0]);
   assign gain_err_b_o = $signed(gain_q[1]);
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
   parameter int SETTLE_CYC = 1000
) (
   input logic clk_i,
   input logic rst_ni,
   input logic mode_bip_i,
   input logic mod_rst_o,
   input logic zero_in_o,
   input logic gain_in_o,
   input logic busy_o,
   input logic done_o
);
   localparam int GW = $clog2(SETTLE_CYC + 1) + 1;

   logic          zero_d;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         zero_d <= 1'b0;
         gap_q  <= '0;
      end else begin
         zero_d <= zero_in_o;
         if (zero_d && !zero_in_o)         gap_q <= GW'(1);
         else if (gap_q < GW'(SETTLE_CYC)) gap_q <= gap_q + GW'(1);
      end
   end

   p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(zero_in_o && gain_in_o));

   p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gain_in_o) |-> (gap_q >= GW'(SETTLE_CYC)));

   p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !(mod_rst_o || zero_in_o || gain_in_o));

   p_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> ($past(gain_in_o) && !gain_in_o && !busy_o));

   p_mode_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(mode_bip_i) |=> !done_o);
endmodule

bind cal_seq_top cal_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mode_bip_i (mode_bip_i),
   .mod_rst_o  (mod_rst_o),
   .zero_in_o  (zero_in_o),
   .gain_in_o  (gain_in_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/cal_seq_top_tb_top.sv
`timescale 1ns/1ps
module cal_seq_top_tb_top;
   localparam int WIN_W  = 15;
   localparam int RES_W  = 24;
   localparam int RSTC   = 4;
   localparam int DVL    = 20;
   localparam int SETTLE = 24;
   localparam int MAXR   = 3;
   localparam int WDOG   = 150000;

   typedef struct packed {
      logic        bip;
      int          win;
      logic [7:0]  za, zb, ga, gb;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{1'b1, 64,  8'hF0, 8'hB4, 8'hD6, 8'hEC},
      '{1'b0, 64,  8'h92, 8'hE0, 8'hD6, 8'h5A},
      '{1'b1, 128, 8'hFE, 8'h01, 8'hFF, 8'h00},
      '{1'b0, 8,   8'h00, 8'hFF, 8'hFF, 8'h00}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic bip = 1'b1;
   logic [WIN_W-1:0] win = '0;
   logic dval = 1'b0;
   logic bit_a = 1'b0, bit_b = 1'b0;
   logic mod_rst, zero_in, gain_in, busy, done, err;
   logic signed [RES_W-1:0] off_a, off_b, gain_a, gain_b;

   always #2 clk = ~clk;

   cal_seq_top #(
      .WIN_W(WIN_W), .RES_W(RES_W), .RST_CYC(RSTC), .DVAL_LOW_CYC(DVL),
      .SETTLE_CYC(SETTLE), .MAX_RETRY(MAXR)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_bip_i(bip),
      .win_len_i(win), .dval_i(dval), .bit_a_i(bit_a), .bit_b_i(bit_b),
      .mod_rst_o(mod_rst), .zero_in_o(zero_in), .gain_in_o(gain_in),
      .off_err_a_o(off_a), .off_err_b_o(off_b),
      .gain_err_a_o(gain_a), .gain_err_b_o(gain_b),
      .busy_o(busy), .done_o(done), .err_o(err)
   );

   int checks = 0, fails = 0;
   logic [7:0] cza = 8'h00, czb = 8'h00, cga = 8'h00, cgb = 8'h00;
   logic [2:0] ph = '0;
   int hold = 0;
   logic force_low = 1'b0;

   // modulator model: rotating patterns, blanked valid after reset
   always @(negedge clk) begin
      ph <= ph + 3'd1;
      bit_a <= zero_in ? cza[ph] : cga[ph];
      bit_b <= zero_in ? czb[ph] : cgb[ph];
      if (mod_rst) hold <= DVL;
      else if (hold > 0) hold <= hold - 1;
      dval <= !mod_rst && hold == 0 && !force_low && rst_n;
   end

   int cyc = 0;
   int t_rr, t_rf, t_zr, t_zf, t_gr, t_gf, t_dr;
   logic p_rst = 0, p_z = 0, p_g = 0, p_d = 0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (mod_rst && !p_rst) t_rr = cyc;
      if (!mod_rst && p_rst) t_rf = cyc;
      if (zero_in && !p_z)   t_zr = cyc;
      if (!zero_in && p_z)   t_zf = cyc;
      if (gain_in && !p_g)   t_gr = cyc;
      if (!gain_in && p_g)   t_gf = cyc;
      if (done && !p_d)      t_dr = cyc;
      p_rst = mod_rst; p_z = zero_in; p_g = gain_in; p_d = done;
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(negedge clk) if (cyc > WDOG) begin
      fails++;
      $display("FAIL watchdog: run exceeded %0d cycles", WDOG);
      summary();
      $finish;
   end

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_err(logic [7:0] pat, int w, int d);
      return ($countones(pat) * w / 8) * 256 - w * d;
   endfunction

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
   endtask

   task automatic wait_zero_rise();
      for (int i = 0; i < 20000 && !zero_in; i++) @(negedge clk);
   endtask

   task automatic load_vec(vec_t v);
      bip = v.bip; win = WIN_W'(v.win);
      cza = v.za; czb = v.zb; cga = v.ga; cgb = v.gb;
   endtask

   task automatic check_results(vec_t v, string tag);
      int dz;
      dz = v.bip ? 128 : 96;
      chk("R6", {tag, " offset A"}, off_a, exp_err(v.za, v.win, dz));
      chk("R6", {tag, " offset B"}, off_b, exp_err(v.zb, v.win, dz));
      chk("R7", {tag, " gain A"}, gain_a, exp_err(v.ga, v.win, 160));
      chk("R7", {tag, " gain B"}, gain_b, exp_err(v.gb, v.win, 160));
   endtask

   initial begin
      tick(3);
      // R12 / R1: reset state
      chk("R1", "reset mod_rst", mod_rst, 0);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset done", done, 0);
      chk("R12", "reset err", err, 0);
      chk("R1", "reset offset A", off_a, 0);
      rst_n = 1'b1;
      tick(3);

      // R1: zero window start ignored
      win = '0;
      pulse_start();
      tick(2);
      chk("R1", "zero window busy", busy, 0);
      chk("R1", "zero window mod_rst", mod_rst, 0);

      // vector table
      foreach (VECS[k]) begin
         load_vec(VECS[k]);
         tick(2);
         pulse_start();
         chk("R1", "busy after start", busy, 1);
         wait_idle();
         tick(1);
         chk("R2", "reset width", t_rf - t_rr, RSTC);
         chk("R3", "reset to zero ctrl", t_zr - t_rf, DVL + SETTLE);
         chk("R4", "zero ctrl width", t_zf - t_zr, SETTLE + VECS[k].win);
         chk("R5", "zero to gain gap", t_gr - t_zf, SETTLE);
         chk("R4", "gain ctrl width", t_gf - t_gr, SETTLE + VECS[k].win);
         chk("R8", "done with gain fall", t_dr, t_gf);
         chk("R8", "done held", done, 1);
         chk("R12", "no abort err", err, 0);
         check_results(VECS[k], $sformatf("vec%0d", k));
      end

      // R11: mode change clears done
      chk("R8", "done before mode flip", done, 1);
      bip = ~bip;
      tick(2);
      chk("R11", "done after mode flip", done, 0);

      // R1: start while busy ignored
      load_vec(VECS[0]);
      tick(2);
      pulse_start();
      for (int i = 0; i < 20000 && !gain_in; i++) @(negedge clk);
      start = 1'b1; tick(1); start = 1'b0;
      wait_idle();
      tick(3);
      chk("R1", "start during run ignored busy", busy, 0);
      chk("R1", "start during run ignored mod_rst", mod_rst, 0);
      chk("R8", "done after clean run", done, 1);

      // R9: single abort inside zero window, then retry
      load_vec(VECS[1]);
      tick(2);
      pulse_start();
      wait_zero_rise();
      tick(SETTLE + 3);
      force_low = 1'b1; tick(1); force_low = 1'b0;
      tick(2);
      chk("R9", "err after abort", err, 1);
      chk("R9", "zero ctrl held on retry", zero_in, 1);
      wait_idle();
      tick(1);
      chk("R9", "done after retry", done, 1);
      check_results(VECS[1], "retry");
      chk("R12", "err holds after run", err, 1);

      // R10: retries exhausted
      load_vec(VECS[0]);
      tick(2);
      pulse_start();
      chk("R12", "err cleared by start", err, 0);
      wait_zero_rise();
      force_low = 1'b1;
      wait_idle();
      tick(1);
      force_low = 1'b0;
      chk("R10", "fail busy", busy, 0);
      chk("R10", "fail done", done, 0);
      chk("R10", "fail err", err, 1);
      chk("R10", "fail zero ctrl", zero_in, 0);
      chk("R10", "fail gain ctrl", gain_in, 0);

      // R11: mode change during a run
      load_vec(VECS[0]);
      tick(2);
      pulse_start();
      wait_zero_rise();
      bip = ~bip;
      wait_idle();
      tick(2);
      chk("R11", "stale run done", done, 0);
      chk("R11", "stale run busy", busy, 0);

      summary();
      $finish;
   end
endmodule